// File: doc/BRIEF.md
# PLL Setting Calculator

This block turns two numbers into the settings of a clock-multiplying PLL that feeds a serial display link. The inputs are a requested bit rate per data lane in kbps and a reference clock in kHz. The outputs are a packed PLL configuration word and a code for the divider of the low-power escape clock. All arithmetic is integer and runs over several cycles. One sequential restoring divider is reused for each quotient, and a separate step-by-step search picks the input divider.

A request is made by pulsing `start` while the block is idle. The inputs are captured at that edge. The results appear together with a one-cycle `done` pulse and then stay constant until the next completion. A zero reference cannot be divided by, so it is reported through `err`. The reset input is asynchronous. It is expected to be deasserted synchronously to `clk`.

The input divider is the largest value that keeps the divided reference at or above 5000 kHz, and it is never larger than 31. The multiplier is the rounded-up ratio that reaches the requested rate. The frequency this produces selects a two-bit range code. The low-power divider is derived from the frequency decoded back out of the packed word, which targets an escape clock of at most 10000 kHz.

Top module: `pll_setting_calc`

## Requirements
- R1: A `start` seen while `busy` is low captures `rate_kbps` and `ref_khz`. For a non-zero reference, `busy` is high from the next cycle. `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle. A `start` given while `busy` is high is ignored and does not change the result.
- R2: When the captured reference is 0, `done` pulses in the cycle after acceptance with `err` = 1, `cfg_word` = 0 and `lp_code` = 0. Any completion with a non-zero reference clears `err`.
- R3: The divider field `cfg_word[12:8]` holds D. D is the largest integer, starting from 1, for which every value d from 2 up to D satisfies reference >= 5000 * d. Equivalently, D = max(1, floor(reference / 5000)), before the cap in R4.
- R4: D never exceeds 31, however large the reference is.
- R5: The multiplier M = ceil(rate * D / reference) is saturated to 255 and placed in `cfg_word[7:0]`. Bit 13 of `cfg_word` is always 0.
- R6: `cfg_word[15:14]` holds a range code based on F = floor(reference * M / D). The code is 3 when F >= 501000, 2 when F >= 251000, 1 when F >= 126000, and 0 otherwise. When M = 0, the code is 0.
- R7: `lp_code` = (N - 1) mod 64, where N = ceil(P / 80000) and P = floor(reference * M' / D). M' is the multiplier field with a value of 0 read as 1.
- R8: After reset, `cfg_word`, `lp_code`, `err`, `done` and `busy` are 0. `cfg_word`, `lp_code` and `err` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| rate_kbps | input | 24 | Requested bit rate per lane in kbps |
| ref_khz | input | 24 | Reference clock in kHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero reference |
| cfg_word | output | 16 | Range code [15:14], zero bit [13], divider [12:8], multiplier [7:0] |
| lp_code | output | 6 | Low-power clock divider code |

## Verification
The ports give little time to hide internal faults, because every result is stored only at the `done` pulse. A divider search that stops one step early or late shows up as a wrong divider field in the first request whose reference lies close to a 5000 kHz multiple. Through that field it also disturbs the multiplier, the range code and the low-power code of the same result. A wrong operand or a miscounted shift in the shared divider corrupts whichever field uses that quotient in the same request. A state machine that stalls or loops shows up as a missing or repeated `done` pulse within a few hundred cycles. The stimulus therefore uses references on both sides of the divider steps and of the cap, rates that land exactly on the range thresholds, a zero rate, a zero reference and saturating multipliers.

// File: rtl/pll_calc_pkg.sv
`timescale 1ns/1ps
package pll_calc_pkg;

  // Controller states of the calculator
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MUL,
    ST_FRQ,
    ST_LPD
  } calc_state_e;

  // Width of the range code field
  localparam int unsigned BAND_W = 2;

  // Default arithmetic constants
  localparam int unsigned DEF_MIN_IF_KHZ = 5000;
  localparam int unsigned DEF_DIV_MAX    = 31;
  localparam int unsigned DEF_LP_KHZ     = 10000;
  localparam int unsigned DEF_BAND1_KHZ  = 126000;
  localparam int unsigned DEF_BAND2_KHZ  = 251000;
  localparam int unsigned DEF_BAND3_KHZ  = 501000;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pll_div_search.sv
`timescale 1ns/1ps
// Iterative input divider search: one candidate per cycle.
module pll_div_search #(
  parameter  int unsigned REF_W   = 24,
  parameter  int unsigned MIN_IF  = 5000,
  parameter  int unsigned DIV_MAX = 31,
  parameter  int unsigned DIV_FW  = 5,
  localparam int unsigned THR_W   = $clog2(MIN_IF * (DIV_MAX + 2)) + 1,
  localparam int unsigned CMP_W   = pll_calc_pkg::max2(REF_W, THR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_khz,
  output logic [DIV_FW-1:0] div_o,
  output logic              done_o
);

  logic              run_q, run_d;
  logic [DIV_FW-1:0] div_q, div_d;
  logic [CMP_W-1:0]  thr_q, thr_d;
  logic              done_q, done_d;
  logic [CMP_W-1:0]  ref_ext;
  logic              step_ok;

  assign ref_ext = CMP_W'(ref_khz);
  // thr_q tracks MIN_IF * (div_q + 1)
  assign step_ok = (ref_ext >= thr_q) && (div_q < DIV_FW'(DIV_MAX));

  always_comb begin
    run_d  = run_q;
    div_d  = div_q;
    thr_d  = thr_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      div_d = DIV_FW'(1);
      thr_d = CMP_W'(2 * MIN_IF);
    end else if (run_q) begin
      if (step_ok) begin
        div_d = div_q + DIV_FW'(1);
        thr_d = thr_q + CMP_W'(MIN_IF);
      end else begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      thr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      div_q  <= div_d;
      thr_q  <= thr_d;
      done_q <= done_d;
    end
  end

  assign div_o  = div_q;
  assign done_o = done_q;

endmodule

// File: rtl/pll_restoring_div.sv
`timescale 1ns/1ps
// Unsigned restoring shift-subtract divider, one quotient bit per cycle.
module pll_restoring_div #(
  parameter  int unsigned DW = 32,
  localparam int unsigned CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);

  logic [DW-1:0] num_q, num_d;
  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [DW:0]   rem_sh;
  logic [DW:0]   rem_sub;
  logic          fits;

  assign rem_sh  = {rem_q, num_q[DW-1]};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign fits    = (rem_sh >= {1'b0, den_q});

  always_comb begin
    num_d  = num_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      num_d = dividend;
      den_d = divisor;
      rem_d = '0;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
      num_d = {num_q[DW-2:0], fits};
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(DW - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      num_q  <= num_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign quotient = num_q;
  assign done     = done_q;

endmodule

// File: rtl/pll_band_enc.sv
`timescale 1ns/1ps
// Frequency range code from the achieved PLL frequency.
module pll_band_enc #(
  parameter int unsigned FW = 32,
  parameter int unsigned BW = 2,
  parameter int unsigned T1 = 126000,
  parameter int unsigned T2 = 251000,
  parameter int unsigned T3 = 501000
) (
  input  logic [FW-1:0] freq,
  input  logic          mul_zero,
  output logic [BW-1:0] band
);

  always_comb begin
    if (mul_zero)               band = '0;
    else if (freq >= FW'(T3))   band = BW'(3);
    else if (freq >= FW'(T2))   band = BW'(2);
    else if (freq >= FW'(T1))   band = BW'(1);
    else                        band = '0;
  end

endmodule

// File: rtl/pll_setting_calc.sv
`timescale 1ns/1ps
module pll_setting_calc
  import pll_calc_pkg::*;
#(
  parameter  int unsigned RATE_W     = 24,
  parameter  int unsigned REF_W      = 24,
  parameter  int unsigned MIN_IF_KHZ = DEF_MIN_IF_KHZ,
  parameter  int unsigned DIV_MAX    = DEF_DIV_MAX,
  parameter  int unsigned MUL_W      = 8,
  parameter  int unsigned LP_KHZ     = DEF_LP_KHZ,
  parameter  int unsigned LP_W       = 6,
  localparam int unsigned DIV_FW     = $clog2(DIV_MAX + 1),
  localparam int unsigned CFG_W      = BAND_W + 1 + DIV_FW + MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_kbps,
  input  logic [REF_W-1:0]  ref_khz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [LP_W-1:0]   lp_code
);

  localparam int unsigned DW      = max2(RATE_W + DIV_FW + 1, REF_W + MUL_W + 1);
  localparam int unsigned LP_STEP = LP_KHZ * 8;

  calc_state_e       state_q, state_d;
  logic [RATE_W-1:0] rate_q;
  logic [REF_W-1:0]  ref_q;
  logic              lat_en;
  logic [DIV_FW-1:0] div_q;
  logic              div_en;
  logic [MUL_W-1:0]  mul_q, mul_sat, mul_eff;
  logic              mul_en;
  logic [BAND_W-1:0] band_q, band_c;
  logic              band_en;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [LP_W-1:0]   lp_q, lp_d;
  logic              err_q, err_d;
  logic              out_en;
  logic              done_q, done_d;

  logic              srch_start, srch_done;
  logic [DIV_FW-1:0] srch_div;
  logic              dv_start, dv_done;
  logic [DW-1:0]     dv_num, dv_den, dv_quo;

  // ---------------------------------------------------------------
  // Datapath helpers
  // ---------------------------------------------------------------
  assign mul_sat = (|(dv_quo >> MUL_W)) ? {MUL_W{1'b1}} : dv_quo[MUL_W-1:0];
  assign mul_eff = (mul_sat == '0) ? MUL_W'(1) : mul_sat;

  pll_div_search #(
    .REF_W   (REF_W),
    .MIN_IF  (MIN_IF_KHZ),
    .DIV_MAX (DIV_MAX),
    .DIV_FW  (DIV_FW)
  ) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (srch_start),
    .ref_khz (ref_q),
    .div_o   (srch_div),
    .done_o  (srch_done)
  );

  pll_restoring_div #(
    .DW (DW)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_num),
    .divisor  (dv_den),
    .quotient (dv_quo),
    .done     (dv_done)
  );

  pll_band_enc #(
    .FW (DW),
    .BW (BAND_W),
    .T1 (DEF_BAND1_KHZ),
    .T2 (DEF_BAND2_KHZ),
    .T3 (DEF_BAND3_KHZ)
  ) u_band (
    .freq     (dv_quo),
    .mul_zero (mul_q == '0),
    .band     (band_c)
  );

  // ---------------------------------------------------------------
  // Sequencer: search, multiplier, achieved frequency, LP divider
  // ---------------------------------------------------------------
  always_comb begin
    state_d    = state_q;
    lat_en     = 1'b0;
    srch_start = 1'b0;
    dv_start   = 1'b0;
    dv_num     = '0;
    dv_den     = '0;
    div_en     = 1'b0;
    mul_en     = 1'b0;
    band_en    = 1'b0;
    out_en     = 1'b0;
    cfg_d      = cfg_q;
    lp_d       = lp_q;
    err_d      = err_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          lat_en = 1'b1;
          if (ref_khz == '0) begin
            out_en = 1'b1;
            cfg_d  = '0;
            lp_d   = '0;
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            srch_start = 1'b1;
            state_d    = ST_SEARCH;
          end
        end
      end
      ST_SEARCH: begin
        if (srch_done) begin
          div_en   = 1'b1;
          dv_start = 1'b1;
          dv_num   = DW'(rate_q) * DW'(srch_div) + DW'(ref_q) - DW'(1);
          dv_den   = DW'(ref_q);
          state_d  = ST_MUL;
        end
      end
      ST_MUL: begin
        if (dv_done) begin
          mul_en   = 1'b1;
          dv_start = 1'b1;
          dv_num   = DW'(ref_q) * DW'(mul_eff);
          dv_den   = DW'(div_q);
          state_d  = ST_FRQ;
        end
      end
      ST_FRQ: begin
        if (dv_done) begin
          band_en  = 1'b1;
          dv_start = 1'b1;
          dv_num   = dv_quo + DW'(LP_STEP - 1);
          dv_den   = DW'(LP_STEP);
          state_d  = ST_LPD;
        end
      end
      ST_LPD: begin
        if (dv_done) begin
          out_en  = 1'b1;
          cfg_d   = {band_q, 1'b0, div_q, mul_q};
          lp_d    = LP_W'(dv_quo - DW'(1));
          err_d   = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ref_q  <= '0;
    end else if (lat_en) begin
      rate_q <= rate_kbps;
      ref_q  <= ref_khz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= srch_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_q <= '0;
    end else if (mul_en) begin
      mul_q <= mul_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
    end else if (band_en) begin
      band_q <= band_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lp_q  <= '0;
      err_q <= 1'b0;
    end else if (out_en) begin
      cfg_q <= cfg_d;
      lp_q  <= lp_d;
      err_q <= err_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign cfg_word = cfg_q;
  assign lp_code  = lp_q;

endmodule

// File: rtl/pll_setting_calc_chk.sv
`timescale 1ns/1ps
module pll_setting_calc_chk #(
  parameter  int unsigned REF_W      = 24,
  parameter  int unsigned MIN_IF_KHZ = 5000,
  parameter  int unsigned DIV_MAX    = 31,
  parameter  int unsigned MUL_W      = 8,
  parameter  int unsigned LP_W       = 6,
  localparam int unsigned DIV_FW     = $clog2(DIV_MAX + 1),
  localparam int unsigned CFG_W      = pll_calc_pkg::BAND_W + 1 + DIV_FW + MUL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [REF_W-1:0] ref_khz,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [CFG_W-1:0] cfg_word,
  input logic [LP_W-1:0]  lp_code
);

  logic [REF_W-1:0]  ref_l;
  logic [DIV_FW-1:0] divf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_l <= '0;
    end else if (start && !busy) begin
      ref_l <= ref_khz;
    end
  end

  assign divf = cfg_word[MUL_W +: DIV_FW];

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (ref_khz != '0)) |=> busy);

  p_idle_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_zero_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (ref_l == '0)));

  p_err_clears_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ((cfg_word == '0) && (lp_code == '0)));

  p_div_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((divf >= DIV_FW'(1)) &&
      ((divf == DIV_FW'(1)) ||
       (64'(ref_l) >= 64'(MIN_IF_KHZ) * 64'(divf)))));

  p_div_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((divf <= DIV_FW'(DIV_MAX)) &&
      ((divf == DIV_FW'(DIV_MAX)) ||
       (64'(ref_l) < 64'(MIN_IF_KHZ) * (64'(divf) + 64'd1)))));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_word[MUL_W + DIV_FW] == 1'b0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cfg_word) && $stable(lp_code) && $stable(err)));

endmodule

bind pll_setting_calc pll_setting_calc_chk #(
  .REF_W      (REF_W),
  .MIN_IF_KHZ (MIN_IF_KHZ),
  .DIV_MAX    (DIV_MAX),
  .MUL_W      (MUL_W),
  .LP_W       (LP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ref_khz  (ref_khz),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .cfg_word (cfg_word),
  .lp_code  (lp_code)
);

// File: tb/pll_setting_calc_test.sv
`timescale 1ns/1ps
module pll_setting_calc_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] rate;
  logic [23:0] refk;
  logic        busy;
  logic        done;
  logic        err;
  logic [15:0] cfg_word;
  logic [5:0]  lp_code;

  int n_chk;
  int n_fail;

  pll_setting_calc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rate_kbps (rate),
    .ref_khz   (refk),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cfg_word  (cfg_word),
    .lp_code   (lp_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected results straight from the requirements
  function automatic void model(input longint unsigned r, input longint unsigned f,
                                output logic [15:0] w, output logic [5:0] lp, output logic e);
    longint unsigned d, m, fr, me, p, n;
    logic [1:0] band;
    if (f == 0) begin
      w = '0; lp = '0; e = 1'b1;
      return;
    end
    d = 1;
    while (f / (d + 1) >= 5000) d++;
    if (d > 31) d = 31;
    m = (r * d + f - 1) / f;
    if (m > 255) m = 255;
    fr = f * m / d;
    if (fr >= 501000)      band = 2'd3;
    else if (fr >= 251000) band = 2'd2;
    else if (fr >= 126000) band = 2'd1;
    else                   band = 2'd0;
    me = (m == 0) ? 1 : m;
    p  = f * me / d;
    n  = (p + 79999) / 80000;
    lp = 6'((n - 1) & 63);
    w  = {band, 1'b0, d[4:0], m[7:0]};
    e  = 1'b0;
  endfunction

  task automatic run_calc(input logic [23:0] r, input logic [23:0] f,
                          input bit poke, input string dtag);
    logic [15:0] ew;
    logic [5:0]  el;
    logic        ee;
    bit          seen;
    model(r, f, ew, el, ee);
    @(negedge clk);
    start = 1'b1; rate = r; refk = f;
    @(negedge clk);
    start = 1'b0;
    if (f != 0) chk("R1 busy after start", busy, 1);
    if (poke && f != 0) begin
      // R1: second request while busy must be ignored
      rate = 24'd777777; refk = 24'd12345; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R1 done reached", seen, 1);
    if (seen) begin
      chk("R1 idle at done", busy, 0);
      chk("R2 err flag", err, ee);
      chk(dtag, cfg_word[12:8], ew[12:8]);
      chk("R5 multiplier field", cfg_word[7:0], ew[7:0]);
      chk("R5 bit 13 zero", cfg_word[13], 0);
      chk("R6 range code", cfg_word[15:14], ew[15:14]);
      chk("R7 lp code", lp_code, el);
      @(negedge clk);
      chk("R1 done single cycle", done, 0);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] hw;
    logic [5:0]  hl;
    logic        he;
    n_chk = 0; n_fail = 0;
    start = 1'b0; rate = '0; refk = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset done", done, 0);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset err", err, 0);
    chk("R8 reset cfg", cfg_word, 0);
    chk("R8 reset lp", lp_code, 0);

    // R2 zero reference, then cleared by a good request
    run_calc(24'd300000, 24'd0, 1'b0, "R2 div on error");
    run_calc(24'd300000, 24'd27000, 1'b0, "R2 err cleared");

    // R3 divider steps
    run_calc(24'd400000, 24'd9999, 1'b0, "R3 div below step");
    run_calc(24'd400000, 24'd10000, 1'b0, "R3 div at step");
    run_calc(24'd400000, 24'd154999, 1'b0, "R3 div thirty");
    // R4 cap
    run_calc(24'd400000, 24'd155000, 1'b0, "R4 div at cap");
    run_calc(24'd400000, 24'd160000, 1'b0, "R4 div past cap");
    run_calc(24'd16000000, 24'd16000000, 1'b0, "R4 div far past cap");

    // R5 saturation, R6/R7 zero rate
    run_calc(24'd1000000, 24'd1000, 1'b0, "R5 sat");
    run_calc(24'd0, 24'd27000, 1'b0, "R6 zero rate");
    // R6 thresholds
    run_calc(24'd120000, 24'd6000, 1'b0, "R6 below band1");
    run_calc(24'd126000, 24'd6000, 1'b0, "R6 band1 edge");
    run_calc(24'd250000, 24'd1000, 1'b0, "R6 below band2");
    run_calc(24'd251000, 24'd1000, 1'b0, "R6 band2 edge");
    run_calc(24'd501000, 24'd3000, 1'b0, "R6 band3 edge");

    // R1 start while busy is ignored
    run_calc(24'd480000, 24'd24000, 1'b1, "R1 ignored start");

    // R8 hold: inputs change without start
    model(24'd480000, 24'd24000, hw, hl, he);
    rate = 24'd5; refk = 24'd7;
    repeat (6) @(negedge clk);
    chk("R8 hold cfg", cfg_word, hw);
    chk("R8 hold lp", lp_code, hl);
    chk("R8 hold err", err, he);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [23:0] rr, ff;
      rr = 24'($urandom_range(0, 1500000));
      ff = 24'($urandom_range(1000, 200000));
      if (k % 8 == 7) ff = 24'($urandom_range(1, 16000000));
      run_calc(rr, ff, (k % 5 == 0), "R3 random div");
    end
    finish_up();
  end

endmodule